// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Set-Less-Than

This block is a purely combinational integer arithmetic and logic unit built from one replicated single-bit slice. Every slice holds a bitwise AND, a bitwise OR and a full adder, and a small multiplexer picks which of these drives that slice's result bit. A three-bit operation code picks bitwise AND, bitwise OR, addition, subtraction or a signed set-less-than compare. A datapath feeds it two operands and reads back the result, a zero indication and the carry from the most significant slice.

Subtraction uses two's complement. The top bit of the operation code inverts operand b in every slice, and the same line feeds the carry into slice 0, which adds the +1. The set-less-than result comes from the sign bit of the difference and is steered only into bit 0. No overflow correction is applied. The carry chain ripples from slice to slice. The carries are formed in one chain module, and the per-bit result logic is generated once per slice.

Top module: `alu_bitsliced`

## Requirements
- R1: Operation code 3'b000 gives result = a AND b, bit by bit.
- R2: Operation code 3'b001 gives result = a OR b, bit by bit.
- R3: Operation code 3'b010 gives result = (a + b) modulo 2^W.
- R4: Operation code 3'b110 gives result = (a - b) modulo 2^W, formed as a + NOT b + 1.
- R5: For code 3'b010, carry_out is bit W of the unsigned sum a + b. For code 3'b110, carry_out is bit W of a + NOT b + 1, which is 1 exactly when a >= b as unsigned numbers.
- R6: Operation code 3'b111 gives result bit 0 equal to bit W-1 of (a - b) modulo 2^W, and all higher result bits 0. No overflow correction is applied, so a = 32'h8000_0000 with b = 1 gives 0.
- R7: Operation codes 3'b011, 3'b100 and 3'b101 give result 0 and carry_out 0.
- R8: zero_flag is 1 exactly when every bit of result is 0, for every operation code.
- R9: carry_out is 0 for codes 3'b000, 3'b001 and 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 3 | Operation select. Bit 2 inverts b and sets the carry into slice 0. Bits 1:0 pick the slice output. |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| result | output | W | Selected result |
| zero_flag | output | 1 | High when result is all zeros |
| carry_out | output | 1 | Carry from the top slice for add and subtract, else 0 |

## Verification
The hardest cases to reach are those where the raw sign of the difference disagrees with the true signed order. This happens only when a - b overflows, for example a most-negative operand against a positive one. Uniform random operands rarely land on the boundary where the sign bit flips. A long ripple across all slices is also hard to hit at random, since it needs operands such as all-ones plus one. The stimulus therefore crosses a directed set of extremes (zero, one, all-ones, most-negative, most-positive) with every operation code, including the unlisted ones. Seeded random pairs then follow, and about half of them reuse a as b, to exercise the equal-operand path of subtract and compare.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_AND = 3'b000;
    localparam logic [OP_W-1:0] OP_OR  = 3'b001;
    localparam logic [OP_W-1:0] OP_ADD = 3'b010;
    localparam logic [OP_W-1:0] OP_SUB = 3'b110;
    localparam logic [OP_W-1:0] OP_SLT = 3'b111;

    // slice output selection, taken from the low two bits of the code
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    typedef struct packed {
        logic       legal;
        logic       inv_b;
        slice_sel_e sel;
        logic       carry_en;
    } op_ctrl_t;

    function automatic logic fa_carry(input logic x, input logic y, input logic ci);
        return (x & y) | (x & ci) | (y & ci);
    endfunction

    function automatic logic fa_sum(input logic x, input logic y, input logic ci);
        return x ^ y ^ ci;
    endfunction

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output op_ctrl_t        ctrl
);
    op_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d          = '0;
        ctrl_d.inv_b    = op_code[2];
        ctrl_d.sel      = slice_sel_e'(op_code[1:0]);
        unique case (op_code)
            OP_AND, OP_OR, OP_SLT: ctrl_d.legal = 1'b1;
            OP_ADD, OP_SUB: begin
                ctrl_d.legal    = 1'b1;
                ctrl_d.carry_en = 1'b1;
            end
            default: ctrl_d.legal = 1'b0;
        endcase
    end

    assign ctrl = ctrl_d;
endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_eff,
    input  logic         cin0,
    output logic [W:0]   carry
);
    logic [W:0] carry_d;

    always_comb begin
        carry_d    = '0;
        carry_d[0] = cin0;
        for (int i = 0; i < W; i++) begin
            carry_d[i+1] = fa_carry(a[i], b_eff[i], carry_d[i]);
        end
    end

    assign carry = carry_d;
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a,
    input  logic       b_eff,
    input  logic       cin,
    input  logic       less,
    input  slice_sel_e sel,
    output logic       sum,
    output logic       res
);
    logic sum_d;
    logic res_d;

    always_comb begin
        sum_d = fa_sum(a, b_eff, cin);
        unique case (sel)
            SEL_AND:  res_d = a & b_eff;
            SEL_OR:   res_d = a | b_eff;
            SEL_SUM:  res_d = sum_d;
            SEL_LESS: res_d = less;
            default:  res_d = 1'b0;
        endcase
    end

    assign sum = sum_d;
    assign res = res_d;
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    output logic         is_zero
);
    assign is_zero = ~(|value);
endmodule

// File: rtl/alu_bitsliced.sv
module alu_bitsliced
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         zero_flag,
    output logic         carry_out
);
    localparam int MSB = W - 1;

    op_ctrl_t   ctrl;
    logic [W-1:0] b_eff;
    logic [W:0]   carry;
    logic [W-1:0] sum_w;
    logic [W-1:0] slice_res;
    logic         set_bit;

    alu_op_decode u_dec (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    assign b_eff = opnd_b ^ {W{ctrl.inv_b}};

    alu_carry_chain #(.W(W)) u_chain (
        .a     (opnd_a),
        .b_eff (b_eff),
        .cin0  (ctrl.inv_b),
        .carry (carry)
    );

    assign set_bit = sum_w[MSB];

    for (genvar i = 0; i < W; i++) begin : g_slice
        if (i == 0) begin : g_lsb
            alu_bit_slice u_bit (
                .a     (opnd_a[i]),
                .b_eff (b_eff[i]),
                .cin   (carry[i]),
                .less  (set_bit),
                .sel   (ctrl.sel),
                .sum   (sum_w[i]),
                .res   (slice_res[i])
            );
        end else begin : g_upper
            alu_bit_slice u_bit (
                .a     (opnd_a[i]),
                .b_eff (b_eff[i]),
                .cin   (carry[i]),
                .less  (1'b0),
                .sel   (ctrl.sel),
                .sum   (sum_w[i]),
                .res   (slice_res[i])
            );
        end
    end

    assign result    = ctrl.legal ? slice_res : '0;
    assign carry_out = ctrl.carry_en & carry[W];

    alu_zero_detect #(.W(W)) u_zero (
        .value   (result),
        .is_zero (zero_flag)
    );

    always_comb begin
        // R3 R5
        add_sum_chk: assert (op_code != OP_ADD ||
            {carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b}));
        // R4
        sub_equal_chk: assert (!(op_code == OP_SUB && opnd_a == opnd_b) ||
            (result == '0 && carry_out));
        // R6
        slt_shape_chk: assert (op_code != OP_SLT || result[W-1:1] == '0);
        // R7
        illegal_op_chk: assert (!(op_code == 3'b011 || op_code == 3'b100 || op_code == 3'b101) ||
            (result == '0 && !carry_out && zero_flag));
        // R8
        zero_flag_chk: assert (!zero_flag || result == '0);
        // R9
        logic_carry_chk: assert (!(op_code == OP_AND || op_code == OP_OR || op_code == OP_SLT) ||
            !carry_out);
    end
endmodule

// File: tb/alu_bitsliced_tb_top.sv
module alu_bitsliced_tb_top;
    localparam int W = 32;
    localparam int RAND_N = 3000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_code = '0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] result;
    logic         zero_flag;
    logic         carry_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu_bitsliced #(.W(W)) dut_i (
        .op_code   (op_code),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .zero_flag (zero_flag),
        .carry_out (carry_out)
    );

    function automatic logic [W:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
        logic [W:0] t;
        case (op)
            3'b000: return {1'b0, a & b};                               // R1
            3'b001: return {1'b0, a | b};                               // R2
            3'b010: return {1'b0, a} + {1'b0, b};                       // R3 R5
            3'b110: return {1'b0, a} + {1'b0, ~b} + 1;                  // R4 R5
            3'b111: begin                                               // R6
                t = {1'b0, a} - {1'b0, b};
                return {1'b0, {(W-1){1'b0}}, t[W-1]};
            end
            default: return '0;                                         // R7
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b110: return "R4";
            3'b111: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] exp;
        logic       exp_c;
        logic       exp_z;
        @(negedge clk);
        op_code = op;
        opnd_a  = a;
        opnd_b  = b;
        @(posedge clk);
        #1;
        exp   = model(op, a, b);
        exp_c = exp[W];
        exp_z = (exp[W-1:0] == '0);
        n_vec++;
        if (result !== exp[W-1:0] || carry_out !== exp_c || zero_flag !== exp_z) begin
            n_bad++;
            if (result !== exp[W-1:0])
                $display("FAIL %s op=%b a=%h b=%h result=%h expected=%h",
                         req_of(op), op, a, b, result, exp[W-1:0]);
            if (carry_out !== exp_c)
                $display("FAIL %s op=%b a=%h b=%h carry_out=%b expected=%b",
                         (op == 3'b010 || op == 3'b110) ? "R5" :
                         (op == 3'b000 || op == 3'b001 || op == 3'b111) ? "R9" : "R7",
                         op, a, b, carry_out, exp_c);
            if (zero_flag !== exp_z)
                $display("FAIL R8 op=%b a=%h b=%h zero_flag=%b expected=%b",
                         op, a, b, zero_flag, exp_z);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired result=%h expected=completion", result);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] corner [6];
        logic [2:0]   ops [8];
        int unused_seed;
        corner[0] = '0;
        corner[1] = 32'h0000_0001;
        corner[2] = '1;
        corner[3] = 32'h8000_0000;
        corner[4] = 32'h7FFF_FFFF;
        corner[5] = 32'hA5A5_5A5A;
        ops = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111, 3'b011, 3'b100, 3'b101};
        unused_seed = $urandom(32'h1234_5678);

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset state: idle inputs give AND of zeros, R8 zero flag set
        apply(3'b000, '0, '0);

        // directed extremes with every code (R1..R9)
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                for (int k = 0; k < 8; k++)
                    apply(ops[k], corner[i], corner[j]);

        // R6 overflow case: raw sign gives 0 even though a < b signed
        apply(3'b111, 32'h8000_0000, 32'h0000_0001);
        // R6 opposite overflow: a > b signed but raw sign is 1
        apply(3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        // R3 R5 full ripple
        apply(3'b010, '1, 32'h0000_0001);
        // R4 R5 borrow
        apply(3'b110, 32'h0000_0000, 32'h0000_0001);

        // seeded random, half with equal operands
        for (int n = 0; n < RAND_N; n++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            logic [2:0]   ro;
            ra = $urandom;
            rb = ($urandom % 2 == 0) ? ra : $urandom;
            ro = ops[$urandom % 8];
            apply(ro, ra, rb);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule